// File: doc/BRIEF.md
# Non-Volatile Program Cycle Controller

This block runs the store of a freshly received DAC setting into the non-volatile copy array of a four-channel programmable voltage source. The serial front end shifts in a start bit, a channel address and a data byte. It then pulses `d7_done` in the cycle in which the final data bit is taken. The controller keeps the address and byte of that frame. On the next rising clock edge it looks at the program request pin. If the request is high, chip select is high and no store is already running, a store begins.

A store lasts a fixed number of clock cycles, `BUSY_CYCLES`. The default models a 4 ms erase/write time at a 1 MHz serial clock. The cycle only advances on clock edges, so the host must keep the clock running. While the store runs, `serial_hold` tells the serial front end to ignore its data input and leave its data output undriven, and the active-low ready output is pulled low. When the count ends, a one-cycle write strobe carries the kept address and byte to the stored-copy array.

A supply-good flag is combined with the ready output. When the supply is too low to program, a request is refused: no busy interval, no strobe, and ready stays high. The host can see this as a failed store.

Top module: `nvp_ctrl`

## Requirements
- R1: After reset `rdy_bsy_n` is 1, `serial_hold` is 0, `store_we` is 0, and `store_addr` and `store_data` are 0.
- R2: A store is accepted when all of the following hold at the rising edge right after the edge that sampled `d7_done` high: `prog` is 1, `cs` is 1, `supply_ok` is 1 and no store is running. From the next cycle, `serial_hold` is 1 and `rdy_bsy_n` is 0.
- R3: If `prog` is 0 or `cs` is 0 at that acceptance edge, no store starts. This applies even if `prog` was 1 during the `d7_done` cycle.
- R4: An accepted store keeps `serial_hold` high and `rdy_bsy_n` low for exactly `BUSY_CYCLES` consecutive cycles.
- R5: `store_we` is 1 for exactly one cycle, the first cycle after the busy interval ends. In that cycle `store_addr` and `store_data` carry the frame's channel address and byte.
- R6: If `supply_ok` is 0 at the acceptance edge, the request is refused: `rdy_bsy_n` stays 1, `serial_hold` stays 0 and no `store_we` pulse occurs.
- R7: A `d7_done` pulse and program request that arrive while a store is running are ignored. The busy interval is not lengthened, and the value written is still the first frame's.
- R8: The address and byte written are those present on `frame_addr` and `frame_data` in the `d7_done` cycle. Later changes on those inputs do not alter them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; the busy interval is counted in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, high while a frame is active |
| prog | input | 1 | Program request from the host |
| d7_done | input | 1 | One-cycle pulse: last data bit of a frame taken |
| frame_addr | input | ADDR_W | Channel address of the frame just completed |
| frame_data | input | DATA_W | Pending data byte of the frame just completed |
| supply_ok | input | 1 | Supply high enough to program |
| rdy_bsy_n | output | 1 | Ready (1) / busy (0) to the host |
| serial_hold | output | 1 | Busy flag to the serial front end: ignore input, release output |
| store_we | output | 1 | One-cycle write strobe to the stored-copy array |
| store_addr | output | ADDR_W | Channel address written |
| store_data | output | DATA_W | Data byte written |

## Verification
The bench sweeps every channel address against a set of data bytes. After each `d7_done` edge it drives inverted values onto the frame inputs. A controller that latched late would then write the complement instead of the frame value. It counts busy cycles and strobes over a window much longer than one store. An off-by-one timer shows up as a busy length other than the parameter, and a strobe issued inside the busy interval shows up as a strobe seen while busy. The bench also covers three refused or ignored requests. In the first, the program request is high only during the last-bit cycle. In the second, chip select or supply is low at the acceptance edge. In the third, a second request arrives mid-store. A design that sampled the request too early, ignored the supply, or restarted its count would show an unexpected busy interval or a second strobe.

// File: rtl/nvp_pkg.sv
package nvp_pkg;

   // Store sequencer phase
   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_BUSY = 1'b1
   } nvp_phase_t;

   // Width of a down/up counter able to hold values 0..n-1
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/nvp_req_sampler.sv
module nvp_req_sampler #(
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              prog,
   input  logic              d7_done,
   input  logic [ADDR_W-1:0] frame_addr,
   input  logic [DATA_W-1:0] frame_data,
   input  logic              supply_ok,
   input  logic              busy,
   output logic              start,
   output logic [ADDR_W-1:0] held_addr,
   output logic [DATA_W-1:0] held_data
);

   logic window_q;
   logic req_ok;

   // window_q marks the cycle whose closing edge is the acceptance edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         window_q <= 1'b0;
      end else begin
         window_q <= d7_done & ~busy;
      end
   end

   // Frame capture is frozen while a store is running
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_addr <= '0;
         held_data <= '0;
      end else if (d7_done && !busy) begin
         held_addr <= frame_addr;
         held_data <= frame_data;
      end
   end

   always_comb begin
      req_ok = window_q & prog & cs & ~busy;
      start  = req_ok & supply_ok;
   end

endmodule

// File: rtl/nvp_busy_timer.sv
module nvp_busy_timer
   import nvp_pkg::*;
#(
   parameter int unsigned BUSY_CYCLES = 4000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic last
);

   localparam int unsigned CW   = cnt_width(BUSY_CYCLES);
   localparam int unsigned LAST = BUSY_CYCLES - 1;

   nvp_phase_t phase_q;

   assign busy = (phase_q == PH_BUSY);

   generate
      if (BUSY_CYCLES == 1) begin : g_single
         // One-cycle store: the busy cycle is also the last one
         assign last = busy;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase_q <= PH_IDLE;
            end else if (start) begin
               phase_q <= PH_BUSY;
            end else begin
               phase_q <= PH_IDLE;
            end
         end
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         assign last = busy && (cnt_q == CW'(LAST));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase_q <= PH_IDLE;
               cnt_q   <= '0;
            end else begin
               unique case (phase_q)
                  PH_IDLE: begin
                     cnt_q <= '0;
                     if (start) begin
                        phase_q <= PH_BUSY;
                     end
                  end
                  PH_BUSY: begin
                     if (cnt_q == CW'(LAST)) begin
                        phase_q <= PH_IDLE;
                        cnt_q   <= '0;
                     end else begin
                        cnt_q <= cnt_q + CW'(1);
                     end
                  end
                  default: phase_q <= PH_IDLE;
               endcase
            end
         end
      end
   endgenerate

endmodule

// File: rtl/nvp_store_port.sv
module nvp_store_port #(
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [ADDR_W-1:0] held_addr,
   input  logic [DATA_W-1:0] held_data,
   output logic              store_we,
   output logic [ADDR_W-1:0] store_addr,
   output logic [DATA_W-1:0] store_data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         store_we   <= 1'b0;
         store_addr <= '0;
         store_data <= '0;
      end else begin
         store_we <= fire;
         if (fire) begin
            store_addr <= held_addr;
            store_data <= held_data;
         end
      end
   end

endmodule

// File: rtl/nvp_ctrl.sv
module nvp_ctrl #(
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned BUSY_CYCLES = 4000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              prog,
   input  logic              d7_done,
   input  logic [ADDR_W-1:0] frame_addr,
   input  logic [DATA_W-1:0] frame_data,
   input  logic              supply_ok,
   output logic              rdy_bsy_n,
   output logic              serial_hold,
   output logic              store_we,
   output logic [ADDR_W-1:0] store_addr,
   output logic [DATA_W-1:0] store_data
);

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("nvp_ctrl: ADDR_W must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("nvp_ctrl: DATA_W must be at least 1");
      end
      if (BUSY_CYCLES < 1) begin : g_bad_busy
         $error("nvp_ctrl: BUSY_CYCLES must be at least 1");
      end
   endgenerate

   logic              start;
   logic              busy;
   logic              last;
   logic [ADDR_W-1:0] held_addr;
   logic [DATA_W-1:0] held_data;

   nvp_req_sampler #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_sampler (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs         (cs),
      .prog       (prog),
      .d7_done    (d7_done),
      .frame_addr (frame_addr),
      .frame_data (frame_data),
      .supply_ok  (supply_ok),
      .busy       (busy),
      .start      (start),
      .held_addr  (held_addr),
      .held_data  (held_data)
   );

   nvp_busy_timer #(
      .BUSY_CYCLES (BUSY_CYCLES)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .busy  (busy),
      .last  (last)
   );

   nvp_store_port #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire       (last),
      .held_addr  (held_addr),
      .held_data  (held_data),
      .store_we   (store_we),
      .store_addr (store_addr),
      .store_data (store_data)
   );

   // Ready is low only during a store; a refused request never enters busy
   assign rdy_bsy_n   = ~busy;
   assign serial_hold = busy;

endmodule

// File: rtl/nvp_ctrl_chk.sv
module nvp_ctrl_chk #(
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned BUSY_CYCLES = 4000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs,
   input logic              prog,
   input logic              d7_done,
   input logic [ADDR_W-1:0] frame_addr,
   input logic [DATA_W-1:0] frame_data,
   input logic              supply_ok,
   input logic              rdy_bsy_n,
   input logic              serial_hold,
   input logic              store_we,
   input logic [ADDR_W-1:0] store_addr,
   input logic [DATA_W-1:0] store_data
);

   logic        win_q;
   int unsigned run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q   <= 1'b0;
         run_len <= 0;
      end else begin
         win_q   <= d7_done;
         run_len <= serial_hold ? run_len + 1 : 0;
      end
   end

   assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (win_q && prog && cs && supply_ok && !serial_hold) |=> (serial_hold && !rdy_bsy_n));

   assert_no_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (win_q && (!prog || !cs) && !serial_hold) |=> !serial_hold);

   assert_busy_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      serial_hold |-> (run_len < BUSY_CYCLES));

   assert_busy_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(serial_hold) |-> (run_len == BUSY_CYCLES));

   assert_strobe_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      store_we |-> $fell(serial_hold));

   assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      store_we |=> !store_we);

   assert_low_supply_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!supply_ok && !serial_hold) |=> (!serial_hold && rdy_bsy_n));

   assert_ready_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(serial_hold) |-> !rdy_bsy_n);

endmodule

bind nvp_ctrl nvp_ctrl_chk #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .BUSY_CYCLES (BUSY_CYCLES)
) u_chk (.*);

// File: tb/nvp_ctrl_tb.sv
module nvp_ctrl_tb;

   localparam int unsigned AW = 2;
   localparam int unsigned DW = 8;
   localparam int unsigned NB = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs = 1'b1;
   logic          prog = 1'b0;
   logic          d7_done = 1'b0;
   logic [AW-1:0] frame_addr = '0;
   logic [DW-1:0] frame_data = '0;
   logic          supply_ok = 1'b1;
   logic          rdy_bsy_n;
   logic          serial_hold;
   logic          store_we;
   logic [AW-1:0] store_addr;
   logic [DW-1:0] store_data;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   nvp_ctrl #(
      .ADDR_W      (AW),
      .DATA_W      (DW),
      .BUSY_CYCLES (NB)
   ) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs          (cs),
      .prog        (prog),
      .d7_done     (d7_done),
      .frame_addr  (frame_addr),
      .frame_data  (frame_data),
      .supply_ok   (supply_ok),
      .rdy_bsy_n   (rdy_bsy_n),
      .serial_hold (serial_hold),
      .store_we    (store_we),
      .store_addr  (store_addr),
      .store_data  (store_data)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // One frame: d7 pulse, then the acceptance-edge values, then observe
   task automatic frame(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic p_acc, input logic c_acc, input logic s_acc,
                        input bit inject, input string req);
      bit exp_go;
      int busy_n;
      int we_n;
      int we_after_busy;
      int got_a;
      int got_d;
      logic prev_busy;
      exp_go = p_acc && c_acc && s_acc;
      @(negedge clk);
      d7_done = 1'b1; frame_addr = a; frame_data = d;
      prog = 1'b1; cs = 1'b1; supply_ok = s_acc;
      @(negedge clk);
      // R8: inputs move right after the capture edge
      d7_done = 1'b0; frame_addr = ~a; frame_data = ~d;
      prog = p_acc; cs = c_acc;
      @(negedge clk);
      check(req, "busy after acceptance edge", int'(serial_hold), int'(exp_go));
      check(req, "ready after acceptance edge", int'(rdy_bsy_n), int'(!exp_go));
      prog = 1'b0; cs = 1'b1;
      busy_n = 0; we_n = 0; we_after_busy = 0; got_a = 0; got_d = 0;
      prev_busy = 1'b0;
      for (int i = 0; i < 20; i++) begin
         if (inject && i == 1) begin
            d7_done = 1'b1; frame_addr = ~a; frame_data = 8'h5A; prog = 1'b1;
         end
         if (inject && i == 2) begin
            d7_done = 1'b0;
         end
         if (inject && i == 3) begin
            prog = 1'b0;
         end
         if (serial_hold) busy_n++;
         if (store_we) begin
            we_n++;
            got_a = int'(store_addr);
            got_d = int'(store_data);
            if (prev_busy && !serial_hold) we_after_busy++;
         end
         prev_busy = serial_hold;
         @(negedge clk);
      end
      supply_ok = 1'b1;
      check(exp_go ? "R4" : req, "busy cycles", busy_n, exp_go ? int'(NB) : 0);
      check(exp_go ? "R5" : req, "strobe count", we_n, exp_go ? 1 : 0);
      if (exp_go) begin
         check("R5", "strobe directly after busy", we_after_busy, 1);
         check("R8", "stored address", got_a, int'(a));
         check("R8", "stored data", got_d, int'(d));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1", "ready", int'(rdy_bsy_n), 1);
      check("R1", "busy", int'(serial_hold), 0);
      check("R1", "strobe", int'(store_we), 0);
      check("R1", "addr", int'(store_addr), 0);
      check("R1", "data", int'(store_data), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R4 R5 R8: every channel against several bytes
      for (int a = 0; a < 4; a++) begin
         for (int k = 0; k < 4; k++) begin
            logic [DW-1:0] dv;
            dv = DW'((k * 8'h55 + a * 8'h13) ^ (k == 3 ? 8'hFF : 8'h00));
            frame(AW'(a), dv, 1'b1, 1'b1, 1'b1, 1'b0, "R2");
         end
      end
      frame(2'd3, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0, "R2");
      frame(2'd0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, "R2");

      // R3: request only during the d7 cycle, or chip select low
      frame(2'd1, 8'hA5, 1'b0, 1'b1, 1'b1, 1'b0, "R3");
      frame(2'd2, 8'h3C, 1'b1, 1'b0, 1'b1, 1'b0, "R3");

      // R6: supply too low
      frame(2'd3, 8'hC3, 1'b1, 1'b1, 1'b0, 1'b0, "R6");

      // R7: second request during the store is ignored
      frame(2'd2, 8'h96, 1'b1, 1'b1, 1'b1, 1'b1, "R7");
      check("R7", "idle after ignored request", int'(serial_hold), 0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #1000000;
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule